// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is the host side of a three-wire link to a 16-bit successive-approximation converter. The wires are an active-low select, a serial clock and returned data. A start request pulls the select low. The block then derives a serial clock from the system clock, toggling it every `HALF_DIV` system cycles, and runs a frame of `FRAME_CLKS` serial periods. It captures the returned bits on rising serial edges and publishes the assembled two's complement word with a one-cycle strobe. The select is raised at the end of every frame, and the converter treats a high select as power-down.

The converter only starts driving its data line after the second falling serial edge of a frame. Bits clocked before that point are therefore thrown away. The select must stay high for at least 20 ns between frames. A frame must span at least 20 serial periods, because the conversion itself occupies 17 of them.

In continuous mode the block repeats frames. Each pause with the select high lasts a run-time number of system cycles, and this sets the sample rate. Elaboration stops with an error in four cases: the parameters give a serial clock outside 1 to 5 MHz, either clock phase is shorter than 20 ns, the frame is shorter than 20 periods, or the frame is too short for the data window.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, cs_no=1, sclk_o=1, valid_o=0, busy_o=0 and data_o=0.
- R2: A start_i seen in idle pulls cs_no low and raises busy_o in the next cycle, with sclk_o still high. The first falling sclk_o edge comes HALF_DIV system cycles after cs_no falls.
- R3: Each frame has exactly FRAME_CLKS rising sclk_o edges. Every sclk_o high or low phase lasts HALF_DIV system cycles, and cs_no stays low for HALF_DIV*(2*FRAME_CLKS+1) cycles, so it rises one phase after the last rising edge.
- R4: Rising sclk_o edges are numbered from 1 within a frame. The sdata_i value at edges 2 through 17 forms data_o, with edge 2 giving bit 15 (MSB) and edge 17 giving bit 0. Values at all other edges are ignored. data_o is two's complement.
- R5: valid_o is high for one cycle per frame, in the cycle cs_no returns high. data_o holds the word from then until the next valid_o.
- R6: start_i is ignored while busy_o is high, so a frame never gets an extra frame queued behind it.
- R7: After each frame, cs_no stays high for exactly max(MIN_GAP_CYC, gap_i) system cycles, and busy_o stays high during that time. MIN_GAP_CYC is the number of cycles covering 20 ns, which is 4 at the defaults.
- R8: If cont_i is high when the pause ends, the next frame begins at once without a new start_i. If cont_i is low, the block returns to idle.
- R9: While idle, cs_no and sclk_o are both held high, which keeps the converter powered down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one frame (taken only when idle) |
| cont_i | input | 1 | Repeat frames while high |
| gap_i | input | GAP_W | Select-high pause in system cycles, floored to MIN_GAP_CYC |
| sdata_i | input | 1 | Serial data from the converter |
| cs_no | output | 1 | Converter select, active low; high means power-down |
| sclk_o | output | 1 | Serial clock, idles high |
| data_o | output | DATA_W | Last signed result |
| valid_o | output | 1 | One-cycle strobe with each new result |
| busy_o | output | 1 | Frame or pause in progress |

## Verification
The converter model pulls its data line high before the data window opens. A reader that captures too early therefore shows stray ones in the top bits, and one that captures on the wrong edge shifts every word by a bit. The word set includes both extremes, the sign boundary and alternating patterns, which exposes sign-bit loss or bit-order reversal. Frame length, phase widths and select-high time are all measured in system cycles. This catches an off-by-one in the edge counter, a pause that ignores the 20 ns floor, and a select that rises together with the last clock edge. A start issued mid-frame and a continuous run that is then switched off show whether a design queues extra frames or fails to stop.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_RUN   = 2'd2,
    ST_GAP   = 2'd3
  } rd_state_e;
endpackage

// File: rtl/adc_rd_clkdiv.sv
module adc_rd_clkdiv #(
  parameter int HALF_DIV = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  a_r3_cnt_cleared_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_o <= '0;
    else if (en_i) word_o <= {word_o[W-2:0], bit_i};
  end

  a_r4_hold_without_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(word_o));
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import adc_rd_pkg::*;
#(
  parameter int SYS_CLK_HZ = 200_000_000,
  parameter int HALF_DIV   = 25,
  parameter int FRAME_CLKS = 20,
  parameter int DATA_W     = 16,
  parameter int GAP_W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cont_i,
  input  logic [GAP_W-1:0]  gap_i,
  input  logic              sdata_i,
  output logic              cs_no,
  output logic              sclk_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              busy_o
);
  localparam longint NS       = 1_000_000_000;
  localparam longint SCLK_HZ  = longint'(SYS_CLK_HZ) / (2 * longint'(HALF_DIV));
  localparam longint PH_NSX   = longint'(HALF_DIV) * NS;       // phase length * f_sys
  localparam longint MIN_GAPL = (20 * longint'(SYS_CLK_HZ) + NS - 1) / NS;
  localparam int     MIN_GAP_CYC = (MIN_GAPL < 1) ? 1 : int'(MIN_GAPL);
  localparam int     DATA_START  = 2;
  localparam int     DATA_END    = DATA_START + DATA_W - 1;
  localparam int     CNT_W       = $clog2(FRAME_CLKS + 1);
  localparam bit     CFG_OK = (SCLK_HZ >= 1_000_000) && (SCLK_HZ <= 5_000_000) &&
                              (PH_NSX >= 20 * longint'(SYS_CLK_HZ)) &&
                              (FRAME_CLKS >= 20) && (FRAME_CLKS >= DATA_END) &&
                              (MIN_GAP_CYC < (1 << GAP_W));

  if (!CFG_OK) begin : g_cfg_err
    $error("adc_frame_reader: serial clock, frame or gap parameters out of range");
  end

  rd_state_e           state_q;
  logic                tick, sclk_q, cs_q, valid_q;
  logic [CNT_W-1:0]    rise_q, next_rise;
  logic [GAP_W-1:0]    gap_q, gap_len;
  logic [DATA_W-1:0]   word, data_q;
  logic                run, rise_now, cap_en;

  assign run       = (state_q == ST_SETUP) || (state_q == ST_RUN);
  assign rise_now  = (state_q == ST_RUN) && tick && !sclk_q;
  assign next_rise = rise_q + 1'b1;
  assign cap_en    = rise_now && (next_rise >= CNT_W'(DATA_START)) &&
                     (next_rise <= CNT_W'(DATA_END));
  assign gap_len   = (gap_i < GAP_W'(MIN_GAP_CYC)) ? GAP_W'(MIN_GAP_CYC) : gap_i;

  adc_rd_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .tick_o(tick)
  );

  adc_rd_shifter #(.W(DATA_W)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (cap_en),
    .bit_i (sdata_i),
    .word_o(word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cs_q    <= 1'b1;
      sclk_q  <= 1'b1;
      rise_q  <= '0;
      valid_q <= 1'b0;
      gap_q   <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_SETUP;
          cs_q    <= 1'b0;
        end
        ST_SETUP: if (tick) begin
          state_q <= ST_RUN;
          sclk_q  <= 1'b0;
          rise_q  <= '0;
        end
        ST_RUN: if (tick) begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rise_q <= next_rise;
          end else if (rise_q == CNT_W'(FRAME_CLKS)) begin
            // hold one phase after the last rise, then deselect
            state_q <= ST_GAP;
            cs_q    <= 1'b1;
            valid_q <= 1'b1;
            data_q  <= word;
            gap_q   <= gap_len - 1'b1;
          end else begin
            sclk_q <= 1'b0;
          end
        end
        ST_GAP: begin
          if (gap_q == '0) begin
            if (cont_i) begin
              state_q <= ST_SETUP;
              cs_q    <= 1'b0;
            end else begin
              state_q <= ST_IDLE;
            end
          end else begin
            gap_q <= gap_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no   = cs_q;
  assign sclk_o  = sclk_q;
  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign busy_o  = (state_q != ST_IDLE);

  a_r5_valid_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  a_r5_valid_at_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> $rose(cs_q));
  a_r9_idle_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (cs_q && sclk_q));
  a_r2_select_with_sclk_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_q) |-> sclk_q);
  a_r3_sclk_low_only_selected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_q |-> !cs_q);
  a_r4_capture_before_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_en |=> (sclk_q && !cs_q));
  a_r6_busy_blocks_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && start_i) |=> (state_q != ST_SETUP));
endmodule

// File: tb/adc_frame_reader_test.sv
module adc_frame_reader_test;
  localparam int HALF_DIV = 25;
  localparam int FRAMES   = 20;
  localparam int MIN_GAP  = 4;   // 20 ns at 5 ns period
  localparam int LOW_LEN  = HALF_DIV * (2 * FRAMES + 1);
  localparam int NV = 8;
  localparam logic [15:0] VEC [NV] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFF,
                                       16'h1234, 16'hA5C3, 16'h0001, 16'hFFFE};

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, cont = 1'b0;
  logic [15:0] gap = 16'd0;
  logic sdo = 1'b1;
  logic cs_n, sclk, valid, busy;
  logic [15:0] data;

  int total = 0, bad = 0;
  logic [15:0] mword = 16'h0;
  int fcnt = 0;

  always #2.5 clk = ~clk;

  adc_frame_reader uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cont_i(cont), .gap_i(gap),
    .sdata_i(sdo), .cs_no(cs_n), .sclk_o(sclk), .data_o(data),
    .valid_o(valid), .busy_o(busy)
  );

  // converter model: line pulled high until after the second falling edge
  always @(negedge cs_n) begin fcnt = 0; sdo = 1'b1; end
  always @(posedge cs_n) sdo = 1'b1;
  always @(negedge sclk) if (cs_n === 1'b0) begin
    fcnt++;
    if (fcnt >= 2 && fcnt <= 17) sdo = mword[17-fcnt];
    else if (fcnt > 17)          sdo = 1'b0;
  end

  // frame monitor
  logic cs_prev = 1'b1, sclk_prev = 1'b1;
  int lo_run = 0, hi_run = 0, ph_run = 0, rises = 0;
  int last_lo = 0, last_hi = 0, last_rises = 0, frames = 0, vcount = 0;
  int ph_min = 1 << 30, ph_max = 0;

  always @(negedge clk) if (rst_n) begin
    if (valid) vcount++;
    if (cs_prev && !cs_n) begin
      if (frames > 0) last_hi = hi_run;
      lo_run = 1; ph_run = 1; rises = 0;
    end else if (!cs_prev && cs_n) begin
      last_lo = lo_run; last_rises = rises;
      if (ph_run < ph_min) ph_min = ph_run;
      if (ph_run > ph_max) ph_max = ph_run;
      hi_run = 1; frames++;
    end else if (!cs_n) begin
      lo_run++;
      if (sclk !== sclk_prev) begin
        if (ph_run < ph_min) ph_min = ph_run;
        if (ph_run > ph_max) ph_max = ph_run;
        ph_run = 1;
        if (sclk) rises++;
      end else ph_run++;
    end else hi_run++;
    cs_prev = cs_n; sclk_prev = sclk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_valid(input string req);
    int n = 0;
    while (valid !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) chk({req, " valid timeout"}, 0, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int f0, v0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cs", cs_n, 1); chk("R1 sclk", sclk, 1);
    chk("R1 valid", valid, 0); chk("R1 busy", busy, 0); chk("R1 data", data, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 idle cs", cs_n, 1); chk("R9 idle sclk", sclk, 1);

    // vector loop: single-shot frames
    for (int i = 0; i < NV; i++) begin
      mword = VEC[i];
      ph_min = 1 << 30; ph_max = 0;
      pulse_start();
      chk("R2 cs low", cs_n, 0); chk("R2 busy", busy, 1); chk("R2 sclk high", sclk, 1);
      wait_valid("R5");
      chk("R4 word", data, VEC[i]);
      chk("R4 sign", $signed(data) < 0, VEC[i][15]);
      chk("R5 cs at valid", cs_n, 1);
      @(negedge clk);
      chk("R5 one cycle", valid, 0);
      chk("R3 rises", last_rises, FRAMES);
      chk("R3 cs low len", last_lo, LOW_LEN);
      chk("R3 phase min", ph_min, HALF_DIV);
      chk("R3 phase max", ph_max, HALF_DIV);
      chk("R7 busy in gap", busy, 1);
      repeat (MIN_GAP + 2) @(negedge clk);
      chk("R9 back idle", {busy, cs_n, sclk}, 3'b011);
      chk("R5 data held", data, VEC[i]);
    end

    // R6: start mid-frame is ignored
    mword = 16'h3C5A; f0 = frames; v0 = vcount;
    pulse_start();
    repeat (200) @(negedge clk);
    pulse_start();
    wait_valid("R6");
    chk("R6 word", data, 16'h3C5A);
    repeat (3000) @(negedge clk);
    chk("R6 frames", frames - f0, 1);
    chk("R6 valids", vcount - v0, 1);
    chk("R6 idle", busy, 0);

    // R8/R7: continuous mode with programmed gap
    gap = 16'd300; cont = 1'b1; mword = 16'h8001; f0 = frames;
    pulse_start();
    wait_valid("R8"); chk("R8 word1", data, 16'h8001);
    @(negedge clk) mword = 16'h7FFE;
    wait_valid("R8"); chk("R8 word2", data, 16'h7FFE);
    chk("R7 gap 300", last_hi, 300);
    @(negedge clk);
    wait_valid("R8");
    cont = 1'b0;
    repeat (3000) @(negedge clk);
    chk("R8 stops", frames - f0, 3);
    chk("R8 idle", {busy, cs_n}, 2'b01);

    // R7: gap floored to 20 ns minimum
    gap = 16'd1; cont = 1'b1; mword = 16'h5555;
    pulse_start();
    wait_valid("R7"); @(negedge clk);
    wait_valid("R7");
    cont = 1'b0;
    chk("R7 min gap", last_hi, MIN_GAP);
    chk("R4 word", data, 16'h5555);
    repeat (2000) @(negedge clk);
    chk("R9 idle end", {busy, cs_n, sclk}, 3'b011);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule